// File: doc/BRIEF.md
# Page-Programmable Flash Array with Spare-Block Substitution

This block models a small flash store made of physical blocks, each holding a fixed number of one-word pages. A table translates logical block numbers into physical ones. Three commands are accepted: page read, page program and block erase. The stored data follows flash rules. Erase drives a whole block to all ones. Program can only pull bits low. Each page has a cap on how many times it can be programmed between erases. Pages inside a block must be filled in order.

The highest physical blocks are held back as a spare pool. An injected fault flag arrives with a command and marks that program or erase as failed on its physical block. For a failed program, the block's pages and bookkeeping are copied one page per cycle into a spare, and the program is then applied there. For a failed erase, the logical block simply moves to a fresh spare, which is already erased. In both cases the failed block is retired and the table entry is redirected. Once no spare is left, a failing operation makes its logical block read-only, so usable capacity shrinks.

A command is taken only when the block is idle. Every command ends with a one-clock completion pulse and a 2-bit status.

Top module: `flash_remap_array`

## Requirements
- R1: After reset every logical block maps to the physical block of the same number, every page reads as all ones, `done` is low and `status` is OK (0).
- R2: An erase (op code 2) sets every page of the addressed block to all ones and clears its program counts and fill position, so page 0 can be programmed again.
- R3: A program (op code 1) stores the old page word AND the command data; bits can only go from 1 to 0.
- R4: With `mlc_mode` low a page takes at most 4 programs between erases, and with it high at most 1. A program beyond the cap returns ILLEGAL (2) and leaves the page unchanged.
- R5: A program is legal only on the next unwritten page of the block, or as a repeat of the most recently written page. Any other page returns ILLEGAL and nothing is stored.
- R6: A faulted program, while a spare is free, moves all pages of the block into a spare, applies the program there, redirects the map and returns REMAPPED (1). Earlier pages read back unchanged.
- R7: A faulted erase, while a spare is free, redirects the logical block to an erased spare and returns REMAPPED. A retired physical block is never mapped again.
- R8: A faulted program or erase with no free spare returns FATAL (3), changes nothing and makes the logical block read-only. Later programs and erases to it return FATAL. Reads still work.
- R9: Each command ends with `done` high for exactly one clock, with `status` valid from that clock on. `cmd_valid` while `busy` is ignored. A logical block number at or beyond the logical count, or op code 3, returns ILLEGAL.
- R10: A read (op code 0) returns, on `rd_data`, the page of the physical block currently mapped. A remap of one logical block leaves the data of the others untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| cmd_blk | input | 3 | Logical block number |
| cmd_page | input | 2 | Page within the block |
| cmd_data | input | 16 | Program data |
| cmd_fault | input | 1 | Marks this program or erase as failing on its physical block |
| mlc_mode | input | 1 | High selects the single-program-per-page cap |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-clock completion pulse |
| status | output | 2 | 0 OK, 1 REMAPPED, 2 ILLEGAL, 3 FATAL |
| rd_data | output | 16 | Page word from the last read |

## Verification
The assertions assume that the fault flag is only honoured on a program or erase that has already passed the read-only, order and count checks. They also assume that the spare pool only shrinks, so a read-only logical block can exist only once every spare is taken. The stimulus issues one command at a time and waits for `done`. It places the single intruding request inside a busy window, and it spends the two spares, one through a failed program and one through a failed erase, before it tries a failure with none left.

// File: rtl/flash_pkg.sv
// Shared encodings for the remapping flash array.
// Assumes: op and status codes are fixed two-bit values seen at the ports.
package flash_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_REMAP   = 2'd1,
        ST_ILLEGAL = 2'd2,
        ST_FATAL   = 2'd3
    } stat_e;

    typedef enum logic [1:0] {
        SOP_NONE  = 2'd0,
        SOP_PROG  = 2'd1,
        SOP_ERASE = 2'd2,
        SOP_COPY  = 2'd3
    } store_op_e;
endpackage

// File: rtl/flash_store.sv
// Page storage plus per-page program counters and per-block fill position.
// Does: AND-programs a page, erases a block to ones, copies one page
// (with its counter and the block fill position) between physical blocks.
// Assumes: PAGES is a power of two; at most one operation per cycle.
module flash_store
    import flash_pkg::*;
#(
    parameter int NPHYS = 8,
    parameter int PAGES = 4,
    parameter int WIDTH = 16,
    parameter int CAP   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  store_op_e                op,
    input  logic [$clog2(NPHYS)-1:0] pb,
    input  logic [$clog2(NPHYS)-1:0] src_pb,
    input  logic [$clog2(PAGES)-1:0] page,
    input  logic [WIDTH-1:0]         data,
    input  logic [$clog2(NPHYS)-1:0] rd_pb,
    input  logic [$clog2(PAGES)-1:0] rd_page,
    output logic [WIDTH-1:0]         rd_word,
    output logic [$clog2(CAP+1)-1:0] rd_cnt,
    output logic [$clog2(PAGES):0]   rd_wptr
);
    localparam int PBW   = $clog2(NPHYS);
    localparam int PGW   = $clog2(PAGES);
    localparam int CW    = $clog2(CAP + 1);
    localparam int WPW   = PGW + 1;
    localparam int WORDS = NPHYS * PAGES;

    logic [WIDTH-1:0] mem  [WORDS];
    logic [CW-1:0]    cnt  [WORDS];
    logic [WPW-1:0]   wptr [NPHYS];

    function automatic int widx(input logic [PBW-1:0] b, input logic [PGW-1:0] p);
        return int'(b) * PAGES + int'(p);
    endfunction

    // Read port: combinational look at one page and its block.
    always_comb begin
        rd_word = mem[widx(rd_pb, rd_page)];
        rd_cnt  = cnt[widx(rd_pb, rd_page)];
        rd_wptr = wptr[rd_pb];
    end

    // Storage update: reset to erased, then apply the requested operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '1;
                cnt[i] <= '0;
            end
            for (int b = 0; b < NPHYS; b++) begin
                wptr[b] <= '0;
            end
        end else begin
            case (op)
                SOP_PROG: begin
                    mem[widx(pb, page)] <= mem[widx(pb, page)] & data;
                    cnt[widx(pb, page)] <= cnt[widx(pb, page)] + CW'(1);
                    if (WPW'(page) + WPW'(1) > wptr[pb]) begin
                        wptr[pb] <= WPW'(page) + WPW'(1);
                    end
                end
                SOP_ERASE: begin
                    for (int p = 0; p < PAGES; p++) begin
                        mem[int'(pb) * PAGES + p] <= '1;
                        cnt[int'(pb) * PAGES + p] <= '0;
                    end
                    wptr[pb] <= '0;
                end
                SOP_COPY: begin
                    mem[widx(pb, page)] <= mem[widx(src_pb, page)];
                    cnt[widx(pb, page)] <= cnt[widx(src_pb, page)];
                    wptr[pb]            <= wptr[src_pb];
                end
                default: ;
            endcase
        end
    end

    // No page counter ever exceeds the largest program cap.
    for (genvar gi = 0; gi < WORDS; gi++) begin : g_cap
        p_cnt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[gi] <= CW'(CAP))
            else $error("page counter above cap");
    end
endmodule

// File: rtl/flash_map.sv
// Logical-to-physical block table, retired-block set, spare pool and
// read-only flags.
// Does: translates a logical block; on alloc retires the current physical
// block and points the entry at the lowest free spare; on ro_set locks it.
// Assumes: alloc is only requested while spare_avail is high.
module flash_map #(
    parameter int NLOG  = 6,
    parameter int NPHYS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NLOG)-1:0]  lblk,
    output logic [$clog2(NPHYS)-1:0] pblk,
    output logic                     lblk_ro,
    output logic                     spare_avail,
    output logic [$clog2(NPHYS)-1:0] spare_pb,
    input  logic                     alloc,
    input  logic                     ro_set
);
    localparam int NSPARE = NPHYS - NLOG;
    localparam int PBW    = $clog2(NPHYS);

    logic [PBW-1:0]    map_tab [NLOG];
    logic [NLOG-1:0]   ro;
    logic [NPHYS-1:0]  bad;
    logic [NSPARE-1:0] free;
    int                spare_idx;

    // Translation and lock lookup, guarded against out-of-range numbers.
    always_comb begin
        if (int'(lblk) < NLOG) begin
            pblk    = map_tab[lblk];
            lblk_ro = ro[lblk];
        end else begin
            pblk    = '0;
            lblk_ro = 1'b0;
        end
    end

    // Pick the lowest-numbered free spare.
    always_comb begin
        spare_idx = 0;
        for (int s = NSPARE - 1; s >= 0; s--) begin
            if (free[s]) spare_idx = s;
        end
        spare_avail = |free;
        spare_pb    = PBW'(NLOG + spare_idx);
    end

    // Table state: identity at reset, redirect on alloc, lock on ro_set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NLOG; l++) map_tab[l] <= PBW'(l);
            ro   <= '0;
            bad  <= '0;
            free <= '1;
        end else if (alloc && int'(lblk) < NLOG) begin
            bad[map_tab[lblk]]   <= 1'b1;
            map_tab[lblk]        <= spare_pb;
            free[spare_idx]      <= 1'b0;
        end else if (ro_set && int'(lblk) < NLOG) begin
            ro[lblk] <= 1'b1;
        end
    end

    // No logical block ever points at a retired physical block.
    for (genvar gl = 0; gl < NLOG; gl++) begin : g_good
        p_map_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !bad[map_tab[gl]])
            else $error("map entry points at retired block");
    end

    // A block can only be locked once the spare pool is empty.
    p_ro_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ro) |-> (free == '0))
        else $error("read-only block while spares remain");

    // Allocation is never requested from an empty pool.
    p_alloc_avail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> spare_avail)
        else $error("alloc with empty pool");
endmodule

// File: rtl/flash_ctrl.sv
// Command sequencer for the remapping flash array.
// Does: accepts one command when idle, checks lock, order and count rules,
// drives the store and the map, runs the page-by-page copy after a failed
// program, and reports status with a one-clock done pulse.
// Assumes: store reads are combinational; map updates land at the next edge.
module flash_ctrl
    import flash_pkg::*;
#(
    parameter int NLOG  = 6,
    parameter int NPHYS = 8,
    parameter int PAGES = 4,
    parameter int WIDTH = 16,
    parameter int CAP   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [$clog2(NLOG)-1:0]  cmd_blk,
    input  logic [$clog2(PAGES)-1:0] cmd_page,
    input  logic [WIDTH-1:0]         cmd_data,
    input  logic                     cmd_fault,
    input  logic                     mlc_mode,
    output logic                     busy,
    output logic                     done,
    output logic [1:0]               status,
    output logic [WIDTH-1:0]         rd_data,
    // map side
    output logic [$clog2(NLOG)-1:0]  m_lblk,
    input  logic [$clog2(NPHYS)-1:0] m_pblk,
    input  logic                     m_ro,
    input  logic                     m_spare_avail,
    input  logic [$clog2(NPHYS)-1:0] m_spare_pb,
    output logic                     m_alloc,
    output logic                     m_ro_set,
    // store side
    output store_op_e                s_op,
    output logic [$clog2(NPHYS)-1:0] s_pb,
    output logic [$clog2(NPHYS)-1:0] s_src,
    output logic [$clog2(PAGES)-1:0] s_page,
    output logic [WIDTH-1:0]         s_data,
    output logic [$clog2(NPHYS)-1:0] s_rd_pb,
    output logic [$clog2(PAGES)-1:0] s_rd_page,
    input  logic [WIDTH-1:0]         s_rd_word,
    input  logic [$clog2(CAP+1)-1:0] s_rd_cnt,
    input  logic [$clog2(PAGES):0]   s_rd_wptr
);
    localparam int PBW = $clog2(NPHYS);
    localparam int PGW = $clog2(PAGES);
    localparam int CW  = $clog2(CAP + 1);
    localparam int WPW = PGW + 1;

    typedef enum logic [1:0] {S_IDLE, S_EXEC, S_COPY, S_APPLY} state_e;

    state_e           state;
    op_e              op_q;
    logic [$clog2(NLOG)-1:0] lblk_q;
    logic [PGW-1:0]   page_q;
    logic [WIDTH-1:0] data_q;
    logic             fault_q;
    logic [PBW-1:0]   src_q, dst_q;
    logic [PGW-1:0]   cidx;
    stat_e            status_q;
    logic             done_q;
    logic [WIDTH-1:0] rd_q;

    logic             blk_ok, seq_ok, cnt_ok, prog_legal, mut_ok;
    logic [CW-1:0]    limit;

    assign busy    = (state != S_IDLE);
    assign done    = done_q;
    assign status  = status_q;
    assign rd_data = rd_q;
    assign m_lblk  = lblk_q;

    // Rule checks for the captured command against the mapped block.
    always_comb begin
        blk_ok     = int'(lblk_q) < NLOG;
        limit      = mlc_mode ? CW'(1) : CW'(CAP);
        seq_ok     = (WPW'(page_q) == s_rd_wptr) ||
                     ((s_rd_wptr != '0) && (WPW'(page_q) == s_rd_wptr - WPW'(1)));
        cnt_ok     = s_rd_cnt < limit;
        prog_legal = seq_ok && cnt_ok;
        mut_ok     = blk_ok && !m_ro &&
                     ((op_q == OP_ERASE) || (op_q == OP_PROG && prog_legal));
    end

    // Store and map drive for the current state.
    always_comb begin
        s_op      = SOP_NONE;
        s_pb      = m_pblk;
        s_src     = src_q;
        s_page    = page_q;
        s_data    = data_q;
        s_rd_pb   = m_pblk;
        s_rd_page = page_q;
        m_alloc   = 1'b0;
        m_ro_set  = 1'b0;
        case (state)
            S_EXEC: begin
                if (mut_ok && !fault_q) begin
                    s_op = (op_q == OP_PROG) ? SOP_PROG : SOP_ERASE;
                end
                m_alloc  = mut_ok && fault_q && m_spare_avail;
                m_ro_set = mut_ok && fault_q && !m_spare_avail;
            end
            S_COPY: begin
                s_op   = SOP_COPY;
                s_pb   = dst_q;
                s_page = cidx;
            end
            S_APPLY: begin
                s_op = SOP_PROG;
                s_pb = dst_q;
            end
            default: ;
        endcase
    end

    // Sequencer: capture, decide, copy, apply, and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_READ;
            lblk_q   <= '0;
            page_q   <= '0;
            data_q   <= '0;
            fault_q  <= 1'b0;
            src_q    <= '0;
            dst_q    <= '0;
            cidx     <= '0;
            status_q <= ST_OK;
            done_q   <= 1'b0;
            rd_q     <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q    <= op_e'(cmd_op);
                        lblk_q  <= cmd_blk;
                        page_q  <= cmd_page;
                        data_q  <= cmd_data;
                        fault_q <= cmd_fault;
                        state   <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                    if (!blk_ok || op_q == OP_RSVD) begin
                        status_q <= ST_ILLEGAL;
                    end else if (op_q == OP_READ) begin
                        rd_q     <= s_rd_word;
                        status_q <= ST_OK;
                    end else if (m_ro) begin
                        status_q <= ST_FATAL;
                    end else if (op_q == OP_PROG && !prog_legal) begin
                        status_q <= ST_ILLEGAL;
                    end else if (!fault_q) begin
                        status_q <= ST_OK;
                    end else if (!m_spare_avail) begin
                        status_q <= ST_FATAL;
                    end else if (op_q == OP_ERASE) begin
                        status_q <= ST_REMAP;
                    end else begin
                        done_q <= 1'b0;
                        src_q  <= m_pblk;
                        dst_q  <= m_spare_pb;
                        cidx   <= '0;
                        state  <= S_COPY;
                    end
                end
                S_COPY: begin
                    cidx <= cidx + PGW'(1);
                    if (cidx == PGW'(PAGES - 1)) state <= S_APPLY;
                end
                S_APPLY: begin
                    status_q <= ST_REMAP;
                    done_q   <= 1'b1;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Completion is a single-clock pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q)
        else $error("done wider than one clock");

    // A remapped completion only follows a command carrying the fault flag.
    p_remap_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && status_q == ST_REMAP) |-> fault_q)
        else $error("remap without fault");

    // Done is never raised while a command is still being worked on.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state == S_IDLE))
        else $error("done while busy");
endmodule

// File: rtl/flash_remap_array.sv
// Top of the flash array with spare-block substitution.
// Does: wires the command sequencer to the block map and page store.
// Assumes: NPHYS > NSPARE; PAGES a power of two; one command in flight.
module flash_remap_array
    import flash_pkg::*;
#(
    parameter int NPHYS  = 8,
    parameter int NSPARE = 2,
    parameter int PAGES  = 4,
    parameter int WIDTH  = 16,
    parameter int CAP    = 4,
    localparam int NLOG  = NPHYS - NSPARE,
    localparam int LBW   = $clog2(NLOG),
    localparam int PGW   = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [LBW-1:0]   cmd_blk,
    input  logic [PGW-1:0]   cmd_page,
    input  logic [WIDTH-1:0] cmd_data,
    input  logic             cmd_fault,
    input  logic             mlc_mode,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic [WIDTH-1:0] rd_data
);
    localparam int PBW = $clog2(NPHYS);
    localparam int CW  = $clog2(CAP + 1);

    logic [LBW-1:0]   m_lblk;
    logic [PBW-1:0]   m_pblk, m_spare_pb;
    logic             m_ro, m_spare_avail, m_alloc, m_ro_set;
    store_op_e        s_op;
    logic [PBW-1:0]   s_pb, s_src, s_rd_pb;
    logic [PGW-1:0]   s_page, s_rd_page;
    logic [WIDTH-1:0] s_data, s_rd_word;
    logic [CW-1:0]    s_rd_cnt;
    logic [PGW:0]     s_rd_wptr;

    flash_ctrl #(.NLOG(NLOG), .NPHYS(NPHYS), .PAGES(PAGES), .WIDTH(WIDTH), .CAP(CAP)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
        .cmd_data(cmd_data), .cmd_fault(cmd_fault), .mlc_mode(mlc_mode),
        .busy(busy), .done(done), .status(status), .rd_data(rd_data),
        .m_lblk(m_lblk), .m_pblk(m_pblk), .m_ro(m_ro), .m_spare_avail(m_spare_avail),
        .m_spare_pb(m_spare_pb), .m_alloc(m_alloc), .m_ro_set(m_ro_set),
        .s_op(s_op), .s_pb(s_pb), .s_src(s_src), .s_page(s_page), .s_data(s_data),
        .s_rd_pb(s_rd_pb), .s_rd_page(s_rd_page), .s_rd_word(s_rd_word),
        .s_rd_cnt(s_rd_cnt), .s_rd_wptr(s_rd_wptr)
    );

    flash_map #(.NLOG(NLOG), .NPHYS(NPHYS)) u_map (
        .clk(clk), .rst_n(rst_n), .lblk(m_lblk), .pblk(m_pblk), .lblk_ro(m_ro),
        .spare_avail(m_spare_avail), .spare_pb(m_spare_pb),
        .alloc(m_alloc), .ro_set(m_ro_set)
    );

    flash_store #(.NPHYS(NPHYS), .PAGES(PAGES), .WIDTH(WIDTH), .CAP(CAP)) u_store (
        .clk(clk), .rst_n(rst_n), .op(s_op), .pb(s_pb), .src_pb(s_src),
        .page(s_page), .data(s_data), .rd_pb(s_rd_pb), .rd_page(s_rd_page),
        .rd_word(s_rd_word), .rd_cnt(s_rd_cnt), .rd_wptr(s_rd_wptr)
    );
endmodule

// File: tb/tb_flash_remap_array.sv
module tb_flash_remap_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_blk = '0;
    logic [1:0]  cmd_page = '0;
    logic [15:0] cmd_data = '0;
    logic        cmd_fault = 1'b0;
    logic        mlc_mode = 1'b0;
    logic        busy, done;
    logic [1:0]  status;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [1:0] RD = 2'd0, PG = 2'd1, ER = 2'd2;
    localparam logic [1:0] OK = 2'd0, RM = 2'd1, IL = 2'd2, FT = 2'd3;

    flash_remap_array dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_page(cmd_page), .cmd_data(cmd_data),
        .cmd_fault(cmd_fault), .mlc_mode(mlc_mode), .busy(busy), .done(done),
        .status(status), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one command, wait for done, check the pulse width and status.
    task automatic cmd(input string req, input logic [1:0] op, input logic [2:0] blk,
                       input logic [1:0] pg, input logic [15:0] d, input logic flt,
                       input logic [1:0] exp_st, input bit intrude = 0);
        int n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_blk = blk; cmd_page = pg;
        cmd_data = d; cmd_fault = flt;
        @(negedge clk);
        if (intrude) begin
            check("R9 busy", {31'd0, busy}, 32'd1);
            cmd_op = ER; cmd_fault = 1'b0; cmd_valid = 1'b1;
        end else begin
            cmd_valid = 1'b0;
        end
        while (!done && n < 100) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            n++;
        end
        cmd_valid = 1'b0; cmd_fault = 1'b0;
        check({req, " status"}, {30'd0, status}, {30'd0, exp_st});
        @(negedge clk);
        check("R9 pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic rd(input string req, input logic [2:0] blk, input logic [1:0] pg,
                      input logic [15:0] exp);
        cmd(req, RD, blk, pg, 16'h0, 1'b0, OK);
        check(req, {16'd0, rd_data}, {16'd0, exp});
    endtask

    task automatic t_reset;
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 status", {30'd0, status}, 32'd0);
        rd("R1", 3'd0, 2'd0, 16'hFFFF);
        rd("R1", 3'd5, 2'd3, 16'hFFFF);
    endtask

    task automatic t_and_program;
        cmd("R3", PG, 3'd0, 2'd0, 16'hF0F0, 1'b0, OK, 1);
        rd("R9 intruding erase ignored", 3'd0, 2'd0, 16'hF0F0);
        cmd("R3", PG, 3'd0, 2'd0, 16'h0FFF, 1'b0, OK);
        rd("R3", 3'd0, 2'd0, 16'h00F0);
    endtask

    task automatic t_order;
        cmd("R5 skip", PG, 3'd0, 2'd2, 16'h0000, 1'b0, IL);
        rd("R5 unchanged", 3'd0, 2'd2, 16'hFFFF);
        cmd("R5 next", PG, 3'd0, 2'd1, 16'h1234, 1'b0, OK);
        cmd("R5 back", PG, 3'd0, 2'd0, 16'h0000, 1'b0, IL);
        rd("R5 back unchanged", 3'd0, 2'd0, 16'h00F0);
    endtask

    task automatic t_count;
        cmd("R4", PG, 3'd1, 2'd0, 16'hFFFE, 1'b0, OK);
        cmd("R4", PG, 3'd1, 2'd0, 16'hFFFD, 1'b0, OK);
        cmd("R4", PG, 3'd1, 2'd0, 16'hFFFB, 1'b0, OK);
        cmd("R4", PG, 3'd1, 2'd0, 16'hFFF7, 1'b0, OK);
        cmd("R4 fifth", PG, 3'd1, 2'd0, 16'h0000, 1'b0, IL);
        rd("R4", 3'd1, 2'd0, 16'hFFF0);
        mlc_mode = 1'b1;
        cmd("R4 mlc", PG, 3'd2, 2'd0, 16'hAAAA, 1'b0, OK);
        cmd("R4 mlc second", PG, 3'd2, 2'd0, 16'h0000, 1'b0, IL);
        rd("R4 mlc", 3'd2, 2'd0, 16'hAAAA);
        mlc_mode = 1'b0;
    endtask

    task automatic t_erase;
        cmd("R2", ER, 3'd1, 2'd0, 16'h0, 1'b0, OK);
        rd("R2", 3'd1, 2'd0, 16'hFFFF);
        cmd("R2 reprogram", PG, 3'd1, 2'd0, 16'h5A5A, 1'b0, OK);
        rd("R2", 3'd1, 2'd0, 16'h5A5A);
    endtask

    task automatic t_illegal_codes;
        cmd("R9 block range", RD, 3'd6, 2'd0, 16'h0, 1'b0, IL);
        cmd("R9 op3", 2'd3, 3'd0, 2'd0, 16'h0, 1'b0, IL);
    endtask

    task automatic t_prog_fault;
        cmd("R6", PG, 3'd0, 2'd2, 16'h5555, 1'b1, RM);
        rd("R6 p0", 3'd0, 2'd0, 16'h00F0);
        rd("R6 p1", 3'd0, 2'd1, 16'h1234);
        rd("R6 p2", 3'd0, 2'd2, 16'h5555);
        rd("R6 p3", 3'd0, 2'd3, 16'hFFFF);
        cmd("R6 order kept", PG, 3'd0, 2'd3, 16'h7777, 1'b0, OK);
        rd("R6", 3'd0, 2'd3, 16'h7777);
        rd("R10 other block", 3'd1, 2'd0, 16'h5A5A);
    endtask

    task automatic t_erase_fault;
        cmd("R7 setup", PG, 3'd3, 2'd0, 16'h0000, 1'b0, OK);
        cmd("R7", ER, 3'd3, 2'd0, 16'h0, 1'b1, RM);
        rd("R7", 3'd3, 2'd0, 16'hFFFF);
        rd("R10 other block", 3'd2, 2'd0, 16'hAAAA);
    endtask

    task automatic t_exhausted;
        cmd("R8", PG, 3'd4, 2'd0, 16'h1111, 1'b1, FT);
        rd("R8 unchanged", 3'd4, 2'd0, 16'hFFFF);
        cmd("R8 locked prog", PG, 3'd4, 2'd0, 16'h1111, 1'b0, FT);
        cmd("R8 locked erase", ER, 3'd4, 2'd0, 16'h0, 1'b0, FT);
        rd("R8 read", 3'd4, 2'd0, 16'hFFFF);
        cmd("R8 other ok", PG, 3'd5, 2'd0, 16'hBEEF, 1'b0, OK);
        rd("R10", 3'd5, 2'd0, 16'hBEEF);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_and_program();
        t_order();
        t_count();
        t_erase();
        t_illegal_codes();
        t_prog_fault();
        t_erase_fault();
        t_exhausted();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule